// File: doc/BRIEF.md
# Time-of-Day Transfer Command Controller

This block keeps a free-running time-of-day count and, when software asks, sends the current count to the timebase of one core. Software uses a single write port that selects one of four registers. The load register starts the count. The target register names the receiving core. The transfer register fires the move. The error register is cleared by writing ones. Reads are not part of this block. All outcomes appear on output pins: the error flags, the transfer strobe and the per-core sent lines.

A target can be named in two ways. The first is a full configuration-bus address, which gives a core base address plus a register offset. The second is a small core number. Both are looked up in a table of core base addresses and core numbers. The table is built from origin and stride parameters. A bad setting never stops the block. It only raises a sticky error flag. A transfer completes only when the selected core reports that it is ready. The block then strobes the captured count onto a data bus for one cycle and raises exactly one core-select line.

Top module: `tod_xfer_ctrl`

## Requirements
- R1: After reset the counter is stopped and reads zero. All error flags are clear, no target is held, and xfer_valid and core_sent are low.
- R2: A write with wr_sel=2 (load) puts the block in the running state. The block stays running until reset. While running, tod_value grows by exactly one per clock.
- R3: A write with wr_sel=0 (target) and wr_data[28] set uses full-address mode. In this mode wr_data[43:32] must equal the parameter TOD_REG_OFS (default 12'h0A4). If it does not, the stored target is left unchanged and err_flags[0] is set.
- R4: In full-address mode, wr_data[63:44] is compared with each table base. Entry i has base BASE_ORIGIN+i*BASE_STRIDE (default 20'h21000+8*i). The lowest matching index becomes the target. If no entry matches, the target becomes invalid and err_flags[2] is set.
- R5: A target write with wr_data[28] clear uses core-ID mode. The ID is wr_data[36:32], which is the 5-bit field, so higher bits are masked off. Entry i has ID ID_ORIGIN+i*ID_STRIDE (default 2+3*i). A hit selects the lowest matching index. A miss makes the target invalid and sets err_flags[2].
- R6: When the parameter ID_MODE_EN is 0, a core-ID-mode target write leaves the stored target unchanged and sets err_flags[1].
- R7: A write with wr_sel=1 (transfer) and wr_data[63] clear sets err_flags[3] and starts no transfer.
- R8: A transfer write with wr_data[63] set while no valid target is held sets err_flags[4] and starts no transfer.
- R9: A transfer write with wr_data[63] set, a valid target i and core_ready[i] high has this effect on the next cycle, for exactly one cycle: xfer_valid is high, core_sent is one-hot on bit i, and xfer_data equals the tod_value seen during the command cycle.
- R10: A transfer write with a valid target i and core_ready[i] low sets err_flags[5] and starts no transfer.
- R11: A write with wr_sel=3 clears each err_flags bit where wr_data[5:0] holds a one. All other flags are unchanged. Every error flag is sticky until it is cleared this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 target, 1 transfer, 2 load, 3 error clear |
| wr_data | input | 64 | Write data |
| core_ready | input | N_CORES | Per-core ready-to-receive indication |
| tod_value | output | 64 | Current time-of-day count |
| tod_running | output | 1 | Counter is running |
| err_flags | output | 6 | Sticky error flags |
| xfer_valid | output | 1 | One-cycle strobe for a completed transfer |
| xfer_data | output | 64 | Count captured by the last transfer |
| core_sent | output | N_CORES | One-hot sent line of the receiving core |

## Verification
The count advancing and a transfer capturing that count happen on the same clock edge. A wrong capture therefore shows up as an off-by-one between the sent value and the counter. The bench samples tod_value just before each transfer edge and requires xfer_data to equal that sample, not the incremented value. A second collision involves a target write that is rejected and the transfer that follows it. The bench judges this by which core_sent line rises: it must be the line of the target held earlier. An instance built with core-ID mode disabled receives the same writes, so its rejection can be compared at the ports against the enabled instance.

// File: rtl/tod_xfer_pkg.sv
package tod_xfer_pkg;

  localparam int TOD_W  = 64;
  localparam int BASE_W = 20;
  localparam int REG_W  = 12;
  localparam int ID_W   = 5;
  localparam int ERR_W  = 6;

  // register select codes
  typedef enum logic [1:0] {
    SEL_TARGET = 2'd0,
    SEL_XFER   = 2'd1,
    SEL_LOAD   = 2'd2,
    SEL_ERRCLR = 2'd3
  } wsel_e;

  // error flag positions
  localparam int ERR_UNIMPL_REG = 0;
  localparam int ERR_ID_OFF     = 1;
  localparam int ERR_NO_MATCH   = 2;
  localparam int ERR_BAD_CMD    = 3;
  localparam int ERR_NO_TARGET  = 4;
  localparam int ERR_NOT_READY  = 5;

  // field extraction from a 64-bit write word (LSB-0 positions)
  function automatic logic f_addr_mode(input logic [TOD_W-1:0] d);
    return d[28];
  endfunction

  function automatic logic [REG_W-1:0] f_reg_part(input logic [TOD_W-1:0] d);
    return d[32 +: REG_W];
  endfunction

  function automatic logic [BASE_W-1:0] f_base_part(input logic [TOD_W-1:0] d);
    return d[32+REG_W +: BASE_W];
  endfunction

  function automatic logic [ID_W-1:0] f_core_id(input logic [TOD_W-1:0] d);
    return d[32 +: ID_W];
  endfunction

  function automatic logic f_cmd_go(input logic [TOD_W-1:0] d);
    return d[TOD_W-1];
  endfunction

  function automatic logic [TOD_W-1:0] f_tod_next(input logic [TOD_W-1:0] t);
    return t + {{(TOD_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_wr,
  output logic             running,
  output logic [TOD_W-1:0] tod
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tod     <= '0;
    end else begin
      if (load_wr) running <= 1'b1;
      if (running) tod <= f_tod_next(tod);
    end
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> (tod == $past(tod) + 64'd1)); // R2

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(tod)); // R1

endmodule

// File: rtl/tod_target_resolver.sv
module tod_target_resolver
  import tod_xfer_pkg::*;
#(
  parameter int N_CORES     = 8,
  parameter bit ID_MODE_EN  = 1'b1,
  parameter int TOD_REG_OFS = 12'h0A4,
  parameter int BASE_ORIGIN = 20'h21000,
  parameter int BASE_STRIDE = 8,
  parameter int ID_ORIGIN   = 2,
  parameter int ID_STRIDE   = 3,
  localparam int IDX_W      = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_wr,
  input  logic              addr_mode,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [BASE_W-1:0] req_base,
  input  logic [ID_W-1:0]   req_id,
  output logic              tgt_valid,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic              ev_unimpl,
  output logic              ev_id_off,
  output logic              ev_no_match
);

  logic [N_CORES-1:0] hit_addr;
  logic [N_CORES-1:0] hit_id;
  logic [N_CORES-1:0] hit_vec;
  logic [IDX_W-1:0]   pick;
  logic               any_hit;
  logic               reject;

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_table
    localparam logic [BASE_W-1:0] ENT_BASE = BASE_W'(BASE_ORIGIN + gi*BASE_STRIDE);
    localparam logic [ID_W-1:0]   ENT_ID   = ID_W'(ID_ORIGIN + gi*ID_STRIDE);
    assign hit_addr[gi] = (req_base == ENT_BASE);
    assign hit_id[gi]   = (req_id == ENT_ID);
  end

  always_comb begin
    hit_vec = addr_mode ? hit_addr : hit_id;
    any_hit = |hit_vec;
    pick    = '0;
    for (int i = N_CORES-1; i >= 0; i--) begin
      if (hit_vec[i]) pick = IDX_W'(i);
    end
  end

  assign reject      = addr_mode ? (req_reg != REG_W'(TOD_REG_OFS)) : !ID_MODE_EN;
  assign ev_unimpl   = tgt_wr && addr_mode && (req_reg != REG_W'(TOD_REG_OFS));
  assign ev_id_off   = tgt_wr && !addr_mode && !ID_MODE_EN;
  assign ev_no_match = tgt_wr && !reject && !any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_valid <= 1'b0;
      tgt_idx   <= '0;
    end else if (tgt_wr && !reject) begin
      tgt_valid <= any_hit;
      if (any_hit) tgt_idx <= pick;
    end
  end

  AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_wr || reject) |=> $stable({tgt_valid, tgt_idx})); // R3

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[pick] && ((hit_vec & ((N_CORES'(1) << pick) - N_CORES'(1))) == '0))); // R4

  AST_MISS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_no_match |=> !tgt_valid); // R5

endmodule

// File: rtl/tod_xfer_engine.sv
module tod_xfer_engine
  import tod_xfer_pkg::*;
#(
  parameter int N_CORES = 8,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic               cmd_go,
  input  logic               tgt_valid,
  input  logic [IDX_W-1:0]   tgt_idx,
  input  logic [N_CORES-1:0] core_ready,
  input  logic [TOD_W-1:0]   tod_now,
  output logic               xfer_valid,
  output logic [TOD_W-1:0]   xfer_data,
  output logic [N_CORES-1:0] core_sent,
  output logic               ev_bad_cmd,
  output logic               ev_no_target,
  output logic               ev_not_ready
);

  logic fire;
  logic tgt_ready;

  assign tgt_ready    = core_ready[tgt_idx];
  assign ev_bad_cmd   = cmd_wr && !cmd_go;
  assign ev_no_target = cmd_wr && cmd_go && !tgt_valid;
  assign ev_not_ready = cmd_wr && cmd_go && tgt_valid && !tgt_ready;
  assign fire         = cmd_wr && cmd_go && tgt_valid && tgt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_data  <= '0;
      core_sent  <= '0;
    end else begin
      xfer_valid <= fire;
      core_sent  <= fire ? (N_CORES'(1) << tgt_idx) : '0;
      if (fire) xfer_data <= tod_now;
    end
  end

  AST_SENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_sent)); // R9

  AST_SENT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sent != '0) |-> (($past(core_ready) & core_sent) == core_sent)); // R10

  AST_SENT_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(cmd_wr && cmd_go)); // R7

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_data == $past(tod_now))); // R9

endmodule

// File: rtl/tod_err_reg.sv
module tod_err_reg
  import tod_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_evt,
  input  logic             clr_wr,
  input  logic [ERR_W-1:0] clr_mask,
  output logic [ERR_W-1:0] err
);

  logic [ERR_W-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= '0;
    else        err <= (err & ~clr_eff) | set_evt;
  end

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((set_evt & clr_mask) == '0)) |=> ((err & $past(clr_mask)) == '0)); // R11

  AST_ERR_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((err & ~$past(err)) != '0) |-> ($past(set_evt) != '0)); // R11

endmodule

// File: rtl/tod_xfer_ctrl.sv
module tod_xfer_ctrl
  import tod_xfer_pkg::*;
#(
  parameter int N_CORES     = 8,
  parameter bit ID_MODE_EN  = 1'b1,
  parameter int TOD_REG_OFS = 12'h0A4,
  parameter int BASE_ORIGIN = 20'h21000,
  parameter int BASE_STRIDE = 8,
  parameter int ID_ORIGIN   = 2,
  parameter int ID_STRIDE   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [63:0]        wr_data,
  input  logic [N_CORES-1:0] core_ready,
  output logic [63:0]        tod_value,
  output logic               tod_running,
  output logic [5:0]         err_flags,
  output logic               xfer_valid,
  output logic [63:0]        xfer_data,
  output logic [N_CORES-1:0] core_sent
);

  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic             tgt_wr, cmd_wr, load_wr, clr_wr;
  logic             tgt_valid;
  logic [IDX_W-1:0] tgt_idx;
  logic             ev_unimpl, ev_id_off, ev_no_match;
  logic             ev_bad_cmd, ev_no_target, ev_not_ready;
  logic [ERR_W-1:0] set_evt;
  logic             unused_wr_bits;

  assign tgt_wr  = wr_en && (wsel_e'(wr_sel) == SEL_TARGET);
  assign cmd_wr  = wr_en && (wsel_e'(wr_sel) == SEL_XFER);
  assign load_wr = wr_en && (wsel_e'(wr_sel) == SEL_LOAD);
  assign clr_wr  = wr_en && (wsel_e'(wr_sel) == SEL_ERRCLR);
  assign unused_wr_bits = ^{wr_data[31:29], wr_data[27:6]};

  tod_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_wr (load_wr),
    .running (tod_running),
    .tod     (tod_value)
  );

  tod_target_resolver #(
    .N_CORES     (N_CORES),
    .ID_MODE_EN  (ID_MODE_EN),
    .TOD_REG_OFS (TOD_REG_OFS),
    .BASE_ORIGIN (BASE_ORIGIN),
    .BASE_STRIDE (BASE_STRIDE),
    .ID_ORIGIN   (ID_ORIGIN),
    .ID_STRIDE   (ID_STRIDE)
  ) u_resolver (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_wr      (tgt_wr),
    .addr_mode   (f_addr_mode(wr_data)),
    .req_reg     (f_reg_part(wr_data)),
    .req_base    (f_base_part(wr_data)),
    .req_id      (f_core_id(wr_data)),
    .tgt_valid   (tgt_valid),
    .tgt_idx     (tgt_idx),
    .ev_unimpl   (ev_unimpl),
    .ev_id_off   (ev_id_off),
    .ev_no_match (ev_no_match)
  );

  tod_xfer_engine #(.N_CORES(N_CORES)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_go       (f_cmd_go(wr_data)),
    .tgt_valid    (tgt_valid),
    .tgt_idx      (tgt_idx),
    .core_ready   (core_ready),
    .tod_now      (tod_value),
    .xfer_valid   (xfer_valid),
    .xfer_data    (xfer_data),
    .core_sent    (core_sent),
    .ev_bad_cmd   (ev_bad_cmd),
    .ev_no_target (ev_no_target),
    .ev_not_ready (ev_not_ready)
  );

  always_comb begin
    set_evt                 = '0;
    set_evt[ERR_UNIMPL_REG] = ev_unimpl;
    set_evt[ERR_ID_OFF]     = ev_id_off;
    set_evt[ERR_NO_MATCH]   = ev_no_match;
    set_evt[ERR_BAD_CMD]    = ev_bad_cmd;
    set_evt[ERR_NO_TARGET]  = ev_no_target;
    set_evt[ERR_NOT_READY]  = ev_not_ready;
  end

  tod_err_reg u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .clr_wr   (clr_wr),
    .clr_mask (wr_data[ERR_W-1:0]),
    .err      (err_flags)
  );

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_evt)); // R11

  AST_SENT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !$past(ev_not_ready || ev_no_target || ev_bad_cmd)); // R8

endmodule

// File: tb/tod_xfer_ctrl_test.sv
`timescale 1ns/1ps
module tod_xfer_ctrl_test;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] data;
    logic [7:0]  rdy;
    logic [7:0]  sent;
    logic [5:0]  err;
  } vec_t;

  function automatic logic [63:0] fa(input logic [19:0] b, input logic [11:0] r);
    return {b, r, 32'h1000_0000};
  endfunction

  function automatic logic [63:0] idt(input logic [4:0] id);
    return {26'h0, 1'b1, id, 32'h0};
  endfunction

  localparam logic [63:0] GO = 64'h8000_0000_0000_0000;
  localparam int NV = 20;

  localparam vec_t VECS [NV] = '{
    '{2'd2, 64'd0,               8'h00, 8'h00, 6'h00}, // R2 load
    '{2'd1, GO,                  8'hFF, 8'h00, 6'h10}, // R8 no target
    '{2'd3, 64'h10,              8'h00, 8'h00, 6'h00}, // R11 clear
    '{2'd0, fa(20'h21010,12'h0A4),8'h00,8'h00, 6'h00}, // R4 idx2
    '{2'd1, GO,                  8'hFF, 8'h04, 6'h00}, // R9 send
    '{2'd1, 64'h1,               8'hFF, 8'h00, 6'h08}, // R7 bad cmd
    '{2'd0, fa(20'h21038,12'h0A5),8'h00,8'h00, 6'h09}, // R3 bad reg
    '{2'd1, GO,                  8'h04, 8'h04, 6'h09}, // R3 old target kept
    '{2'd0, idt(5'd23),          8'h00, 8'h00, 6'h09}, // R5 id 23 -> idx7
    '{2'd1, GO,                  8'h7F, 8'h00, 6'h29}, // R10 not ready
    '{2'd1, GO,                  8'h80, 8'h80, 6'h29}, // R9 idx7
    '{2'd0, idt(5'd3),           8'h00, 8'h00, 6'h2D}, // R5 miss
    '{2'd1, GO,                  8'hFF, 8'h00, 6'h3D}, // R8 invalidated
    '{2'd3, 64'h05,              8'h00, 8'h00, 6'h38}, // R11 partial clear
    '{2'd0, fa(20'h21004,12'h0A4),8'h00,8'h00, 6'h3C}, // R4 miss
    '{2'd0, fa(20'h21000,12'h0A4),8'h00,8'h00, 6'h3C}, // R4 idx0
    '{2'd1, GO,                  8'h01, 8'h01, 6'h3C}, // R9 idx0
    '{2'd3, 64'h3F,              8'h00, 8'h00, 6'h00}, // R11 clear all
    '{2'd0, idt(5'd5),           8'h00, 8'h00, 6'h00}, // R5 id 5 -> idx1
    '{2'd1, GO,                  8'h02, 8'h02, 6'h00}  // R9 idx1
  };

  string vtag [NV] = '{"R2","R8","R11","R4","R9","R7","R3","R3","R5","R10",
                       "R9","R5","R8","R11","R4","R4","R9","R11","R5","R9"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = 64'd0;
  logic [7:0]  core_ready = 8'h00;
  logic [63:0] tod_value, xfer_data, n_tod, n_xdata;
  logic        tod_running, xfer_valid, n_run, n_xvalid;
  logic [5:0]  err_flags, n_err;
  logic [7:0]  core_sent, n_sent;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tod_xfer_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .core_ready(core_ready), .tod_value(tod_value), .tod_running(tod_running),
    .err_flags(err_flags), .xfer_valid(xfer_valid), .xfer_data(xfer_data),
    .core_sent(core_sent)
  );

  tod_xfer_ctrl #(.ID_MODE_EN(1'b0)) uut_noid (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .core_ready(core_ready), .tod_value(n_tod), .tod_running(n_run),
    .err_flags(n_err), .xfer_valid(n_xvalid), .xfer_data(n_xdata),
    .core_sent(n_sent)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d, input logic [7:0] r);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d; core_ready = r;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tod", tod_value, 64'd0);
    chk("R1 running", {63'd0, tod_running}, 64'd0);
    chk("R1 err", {58'd0, err_flags}, 64'd0);
    chk("R1 sent", {55'd0, xfer_valid, core_sent}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R1 stopped count", tod_value, 64'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = VECS[v].op; wr_data = VECS[v].data; core_ready = VECS[v].rdy;
      snap = tod_value;
      @(negedge clk);
      wr_en = 1'b0;
      chk({vtag[v], " sent"}, {56'd0, core_sent}, {56'd0, VECS[v].sent});
      chk({vtag[v], " valid"}, {63'd0, xfer_valid}, {63'd0, (VECS[v].sent != 8'h00)});
      chk({vtag[v], " err"}, {58'd0, err_flags}, {58'd0, VECS[v].err});
      if (VECS[v].sent != 8'h00) chk({vtag[v], " data"}, xfer_data, snap);
    end

    // R9 pulse lasts one cycle
    @(negedge clk);
    chk("R9 pulse end", {55'd0, xfer_valid, core_sent}, 64'd0);

    // R2 count rate
    snap = tod_value;
    repeat (5) @(negedge clk);
    chk("R2 rate", tod_value, snap + 64'd5);
    chk("R2 running", {63'd0, tod_running}, 64'd1);

    // R6 core-ID mode disabled instance keeps its earlier target
    wr(2'd3, 64'h3F, 8'h00);
    wr(2'd0, fa(20'h21018, 12'h0A4), 8'h00);
    wr(2'd0, idt(5'd5), 8'h00);
    chk("R6 noid err", {58'd0, n_err}, 64'h02);
    chk("R5 enabled err", {58'd0, err_flags}, 64'h00);
    wr(2'd1, GO, 8'hFF);
    chk("R6 noid old target", {56'd0, n_sent}, 64'h08);
    chk("R5 enabled new target", {56'd0, core_sent}, 64'h02);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule